// File: doc/BRIEF.md
# Dual-Clock FIFO with Level Flags and Rewind

This block is the storage and status core of a first-in first-out buffer whose writer and reader run on unrelated clocks. The writer presents a word and pulls its active-low write enable. The reader pulls its active-low read enable and finds the next word in an output register one read-clock edge later. Five active-low level flags describe how full the buffer is: empty, almost empty, half full, almost full and full. The two almost flags compare the stored word count with offsets that the integrator drives on two input buses. A value of 127 on both buses is the usual setting for a deep buffer.

Each pointer crosses to the opposite clock as Gray code through a two-stage synchroniser. The empty flag belongs to the read clock and the full flag belongs to the write clock. A mode input chooses how the almost flags are produced. In one setting each is a register in its own clock domain. In the other setting each is decoded directly from the two raw pointers. A rewind input returns the read pointer to storage location zero, so the data written since reset can be read out again.

Top module: `dcf_flag_engine`

## Requirements
- R1: `empty_n_o` is low exactly when no words are stored. It changes only on rising `rclk_i` edges.
- R2: `full_n_o` is low exactly when DEPTH (2^ADDR_W) words are stored. It changes only on rising `wclk_i` edges. A write attempted while `full_n_o` is low stores nothing and leaves the stored words intact.
- R3: A read attempted while `empty_n_o` is low moves no pointer. `dout_o` keeps the last word that was validly read.
- R4: `ae_n_o` is low when the stored count is at most `ae_off_i`.
- R5: `af_n_o` is low when the stored count is at least DEPTH minus `af_off_i`.
- R6: `hf_n_o` is low when the stored count is greater than DEPTH/2.
- R7: When `sync_mode_i` = 1, `ae_n_o` is a register clocked by `rclk_i` and `af_n_o` is a register clocked by `wclk_i`. When `sync_mode_i` = 0, both are decoded combinationally from the two pointers. Once traffic stops, both settings show the same levels.
- R8: Words leave in the order they were written. A read accepted on a rising `rclk_i` edge places its word on `dout_o` at that same edge.
- R9: `rt_i` high on a rising `rclk_i` edge, with `wen_n_i` and `ren_n_i` both high, sets the read pointer to location zero. Later reads replay the words written since reset, and the flags follow the new count. The rewind is valid when no more than DEPTH words have been written since reset.
- R10: `rt_i` is ignored on any edge where `ren_n_i` or `wen_n_i` is low.
- R11: While `rst_n_i` is low, and for at least three edges of each clock, the block goes to this state: `empty_n_o` and `ae_n_o` low, `hf_n_o`, `af_n_o` and `full_n_o` high, and `dout_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock, unrelated to the write clock |
| rst_n_i | input | 1 | Synchronous active-low reset, seen by both clocks |
| wen_n_i | input | 1 | Active-low write enable |
| din_i | input | DATA_W | Word to be written |
| ren_n_i | input | 1 | Active-low read enable |
| dout_o | output | DATA_W | Output register holding the last word read |
| rt_i | input | 1 | Rewind the read pointer to location zero |
| sync_mode_i | input | 1 | 1: almost flags registered; 0: almost flags decoded from pointers |
| ae_off_i | input | ADDR_W+1 | Almost-empty offset (count threshold) |
| af_off_i | input | ADDR_W+1 | Almost-full offset (distance from DEPTH) |
| empty_n_o | output | 1 | Low when empty |
| ae_n_o | output | 1 | Low when almost empty |
| hf_n_o | output | 1 | Low when more than half full |
| af_n_o | output | 1 | Low when almost full |
| full_n_o | output | 1 | Low when full |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 18, which gives a sixteen-word buffer. With that depth the bench can fill the buffer word by word and drain it again. It checks every flag one word on each side of its threshold, in both almost-flag modes. The small depth also makes the pointers wrap several times during a streamed run. The write clock runs at 4 ns and the read clock at 6.6 ns, and their edges never line up, so the Gray crossings are exercised at many relative phases. Offsets of 3 and 4 place the almost thresholds away from the empty and full boundaries. Offsets of zero make those thresholds coincide with the boundaries.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock FIFO flag engine.
package dcf_pkg;

    // Choice of how the two almost flags are produced.
    typedef enum logic {
        ALM_DECODED    = 1'b0,
        ALM_REGISTERED = 1'b1
    } alm_mode_e;

endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, followed by conversion to binary.
// Assumes the source changes by at most one bit per source-clock edge,
// except while both sides are idle (for example around a rewind).
module dcf_ptr_sync #(
    parameter int PW = 9
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);

    logic [PW-1:0] stage1;
    logic [PW-1:0] stage2;

    // Two register stages into the destination clock.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_i;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at and above it.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            bin_o[i] = ^(stage2 >> i);
        end
    end

endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side control: write pointer, its Gray copy, full flag and registered almost-full.
// Assumes the read pointer arrives already synchronised to wclk.
module dcf_wr_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              wclk_i,
    input  logic              rst_n_i,
    input  logic              wen_n_i,
    input  logic [ADDR_W:0]   rptr_s_i,
    input  logic [ADDR_W:0]   af_off_i,
    output logic              wr_go_o,
    output logic [ADDR_W:0]   wptr_o,
    output logic [ADDR_W:0]   wgray_o,
    output logic              full_n_o,
    output logic              af_reg_n_o
);

    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] cnt_nxt;
    logic [PW:0]   af_sum;

    // Accept a write only while not full.
    assign wr_go_o  = !wen_n_i && full_n_o;
    assign wptr_nxt = wptr_o + PW'(wr_go_o);
    assign cnt_nxt  = wptr_nxt - rptr_s_i;
    assign af_sum   = {1'b0, cnt_nxt} + {1'b0, af_off_i};

    // Pointer, Gray copy and write-domain flags.
    always_ff @(posedge wclk_i) begin
        if (!rst_n_i) begin
            wptr_o     <= '0;
            wgray_o    <= '0;
            full_n_o   <= 1'b1;
            af_reg_n_o <= 1'b1;
        end else begin
            wptr_o     <= wptr_nxt;
            wgray_o    <= wptr_nxt ^ (wptr_nxt >> 1);
            full_n_o   <= (cnt_nxt != DEPTH_P);
            af_reg_n_o <= (af_sum < {1'b0, DEPTH_P});
        end
    end

endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side control: read pointer with rewind, its Gray copy, empty flag and
// registered almost-empty. Assumes the write pointer arrives synchronised to rclk.
module dcf_rd_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              rclk_i,
    input  logic              rst_n_i,
    input  logic              ren_n_i,
    input  logic              wen_n_i,
    input  logic              rt_i,
    input  logic [ADDR_W:0]   wptr_s_i,
    input  logic [ADDR_W:0]   ae_off_i,
    output logic              rd_go_o,
    output logic [ADDR_W:0]   rptr_o,
    output logic [ADDR_W:0]   rgray_o,
    output logic              empty_n_o,
    output logic              ae_reg_n_o
);

    localparam int PW = ADDR_W + 1;

    logic          rewind;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] cnt_nxt;

    // Reads need a non-empty buffer; a rewind needs both enables idle.
    assign rd_go_o  = !ren_n_i && empty_n_o;
    assign rewind   = rt_i && ren_n_i && wen_n_i;
    assign rptr_nxt = rewind ? '0 : rptr_o + PW'(rd_go_o);
    assign cnt_nxt  = wptr_s_i - rptr_nxt;

    // Pointer, Gray copy and read-domain flags.
    always_ff @(posedge rclk_i) begin
        if (!rst_n_i) begin
            rptr_o     <= '0;
            rgray_o    <= '0;
            empty_n_o  <= 1'b0;
            ae_reg_n_o <= 1'b0;
        end else begin
            rptr_o     <= rptr_nxt;
            rgray_o    <= rptr_nxt ^ (rptr_nxt >> 1);
            empty_n_o  <= (cnt_nxt != '0);
            ae_reg_n_o <= (cnt_nxt > ae_off_i);
        end
    end

endmodule

// File: rtl/dcf_flag_engine.sv
// Dual-clock FIFO core with five active-low level flags and a read rewind.
// Assumes rst_n_i is held low for at least three edges of each clock, and
// both enables stay idle for three edges of each clock around a rewind.
module dcf_flag_engine #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              wclk_i,
    input  logic              rclk_i,
    input  logic              rst_n_i,
    input  logic              wen_n_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ren_n_i,
    output logic [DATA_W-1:0] dout_o,
    input  logic              rt_i,
    input  logic              sync_mode_i,
    input  logic [ADDR_W:0]   ae_off_i,
    input  logic [ADDR_W:0]   af_off_i,
    output logic              empty_n_o,
    output logic              ae_n_o,
    output logic              hf_n_o,
    output logic              af_n_o,
    output logic              full_n_o
);

    import dcf_pkg::*;

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [PW-1:0] HALF_P  = DEPTH_P >> 1;

    logic [DATA_W-1:0] mem [DEPTH];

    logic          wr_go, rd_go;
    logic [PW-1:0] wptr_bin, wgray, rptr_bin, rgray;
    logic [PW-1:0] wptr_s, rptr_s;
    logic          ae_reg_n, af_reg_n;
    logic [PW-1:0] cnt_raw;
    logic [PW:0]   af_sum_raw;
    logic          ae_dec_n, af_dec_n;

    dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk_i     (wclk_i),
        .rst_n_i    (rst_n_i),
        .wen_n_i    (wen_n_i),
        .rptr_s_i   (rptr_s),
        .af_off_i   (af_off_i),
        .wr_go_o    (wr_go),
        .wptr_o     (wptr_bin),
        .wgray_o    (wgray),
        .full_n_o   (full_n_o),
        .af_reg_n_o (af_reg_n)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .rclk_i     (rclk_i),
        .rst_n_i    (rst_n_i),
        .ren_n_i    (ren_n_i),
        .wen_n_i    (wen_n_i),
        .rt_i       (rt_i),
        .wptr_s_i   (wptr_s),
        .ae_off_i   (ae_off_i),
        .rd_go_o    (rd_go),
        .rptr_o     (rptr_bin),
        .rgray_o    (rgray),
        .empty_n_o  (empty_n_o),
        .ae_reg_n_o (ae_reg_n)
    );

    dcf_ptr_sync #(.PW(PW)) u_sync_w2r (
        .clk_i   (rclk_i),
        .rst_n_i (rst_n_i),
        .gray_i  (wgray),
        .bin_o   (wptr_s)
    );

    dcf_ptr_sync #(.PW(PW)) u_sync_r2w (
        .clk_i   (wclk_i),
        .rst_n_i (rst_n_i),
        .gray_i  (rgray),
        .bin_o   (rptr_s)
    );

    // Storage write port.
    always_ff @(posedge wclk_i) begin
        if (wr_go) begin
            mem[wptr_bin[ADDR_W-1:0]] <= din_i;
        end
    end

    // Output register: loads only on an accepted read.
    always_ff @(posedge rclk_i) begin
        if (!rst_n_i) begin
            dout_o <= '0;
        end else if (rd_go) begin
            dout_o <= mem[rptr_bin[ADDR_W-1:0]];
        end
    end

    // Flags decoded directly from the two raw pointers.
    assign cnt_raw    = wptr_bin - rptr_bin;
    assign af_sum_raw = {1'b0, cnt_raw} + {1'b0, af_off_i};
    assign ae_dec_n   = (cnt_raw > ae_off_i);
    assign af_dec_n   = (af_sum_raw < {1'b0, DEPTH_P});
    assign hf_n_o     = !(cnt_raw > HALF_P);

    // Mode selection for the almost flags.
    assign ae_n_o = (alm_mode_e'(sync_mode_i) == ALM_REGISTERED) ? ae_reg_n : ae_dec_n;
    assign af_n_o = (alm_mode_e'(sync_mode_i) == ALM_REGISTERED) ? af_reg_n : af_dec_n;

endmodule

// File: rtl/dcf_flag_engine_chk.sv
// Property checker for dcf_flag_engine, attached with bind below.
module dcf_flag_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input logic              wclk_i,
    input logic              rclk_i,
    input logic              rst_n_i,
    input logic              rt_i,
    input logic              sync_mode_i,
    input logic              empty_n_o,
    input logic              full_n_o,
    input logic              ae_n_o,
    input logic              af_n_o,
    input logic [DATA_W-1:0] dout_o,
    input logic [ADDR_W:0]   wptr_bin,
    input logic [ADDR_W:0]   rptr_bin
);

    // R2: the write pointer holds still while full.
    a_r2_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_n_i)
        !full_n_o |=> $stable(wptr_bin));

    // R3: the read pointer holds still while empty, unless a rewind is requested.
    a_r3_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
        (!empty_n_o && !rt_i) |=> $stable(rptr_bin));

    // R3: the output register keeps its word while empty.
    a_r3_hold_dout: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
        !empty_n_o |=> $stable(dout_o));

    // R5: in registered mode, full implies almost full.
    a_r5_full_implies_af: assert property (@(posedge wclk_i) disable iff (!rst_n_i)
        (sync_mode_i && !full_n_o) |-> !af_n_o);

    // R4: in registered mode, empty implies almost empty.
    a_r4_empty_implies_ae: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
        (sync_mode_i && !empty_n_o) |-> !ae_n_o);

endmodule

bind dcf_flag_engine dcf_flag_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .wclk_i      (wclk_i),
    .rclk_i      (rclk_i),
    .rst_n_i     (rst_n_i),
    .rt_i        (rt_i),
    .sync_mode_i (sync_mode_i),
    .empty_n_o   (empty_n_o),
    .full_n_o    (full_n_o),
    .ae_n_o      (ae_n_o),
    .af_n_o      (af_n_o),
    .dout_o      (dout_o),
    .wptr_bin    (wptr_bin),
    .rptr_bin    (rptr_bin)
);

// File: tb/dcf_flag_engine_tb.sv
`timescale 1ns/1ps
module dcf_flag_engine_tb;

    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_n = 1'b1;
    logic          ren_n = 1'b1;
    logic          rt = 1'b0;
    logic          smode = 1'b1;
    logic [DW-1:0] din = '0;
    logic [PW-1:0] ae_off = PW'(3);
    logic [PW-1:0] af_off = PW'(4);
    logic [DW-1:0] dout;
    logic          empty_n, ae_n, hf_n, af_n, full_n;

    int n_chk = 0;
    int n_err = 0;
    int level = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];
    logic [DW-1:0] last_rd = '0;

    dcf_flag_engine #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .wclk_i      (wclk),
        .rclk_i      (rclk),
        .rst_n_i     (rst_n),
        .wen_n_i     (wen_n),
        .din_i       (din),
        .ren_n_i     (ren_n),
        .dout_o      (dout),
        .rt_i        (rt),
        .sync_mode_i (smode),
        .ae_off_i    (ae_off),
        .af_off_i    (af_off),
        .empty_n_o   (empty_n),
        .ae_n_o      (ae_n),
        .hf_n_o      (hf_n),
        .af_n_o      (af_n),
        .full_n_o    (full_n)
    );

    always #2 wclk = ~wclk;
    initial begin
        #0.25;
        forever #3.3 rclk = ~rclk;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Settle, then compare all five flags against the count, in both modes.
    task automatic check_levels(input int cnt);
        for (int m = 0; m < 2; m++) begin
            smode = m[0];
            #100;
            check("R1", $sformatf("empty_n cnt=%0d mode=%0d", cnt, m), int'(empty_n), int'(cnt != 0));
            check("R4/R7", $sformatf("ae_n cnt=%0d mode=%0d", cnt, m), int'(ae_n), int'(cnt > int'(ae_off)));
            check("R6", $sformatf("hf_n cnt=%0d mode=%0d", cnt, m), int'(hf_n), int'(!(cnt > DEPTH / 2)));
            check("R5/R7", $sformatf("af_n cnt=%0d mode=%0d", cnt, m), int'(af_n),
                  int'(cnt < DEPTH - int'(af_off)));
            check("R2", $sformatf("full_n cnt=%0d mode=%0d", cnt, m), int'(full_n), int'(cnt != DEPTH));
        end
        smode = 1'b1;
    endtask

    task automatic do_reset();
        wen_n = 1'b1;
        ren_n = 1'b1;
        rt    = 1'b0;
        rst_n = 1'b0;
        repeat (6) @(negedge rclk);
        rst_n = 1'b1;
        q.delete();
        hist.delete();
        level   = 0;
        last_rd = '0;
        #100;
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wclk);
        wen_n = 1'b0;
        din   = d;
        @(negedge wclk);
        wen_n = 1'b1;
        if (level < DEPTH) begin
            level++;
            q.push_back(d);
            hist.push_back(d);
        end
    endtask

    task automatic pop_check(input string req);
        logic [DW-1:0] exp;
        @(negedge rclk);
        ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
        if (level > 0) begin
            exp = q.pop_front();
            level--;
            last_rd = exp;
        end else begin
            exp = last_rd;
        end
        check(req, "dout", int'(dout), int'(exp));
    endtask

    // R11: state after reset.
    task automatic t_reset();
        do_reset();
        check("R11", "dout after reset", int'(dout), 0);
        check_levels(0);
    endtask

    // R1 R2 R4 R5 R6: fill word by word and check each threshold from below.
    task automatic t_fill_sweep();
        for (int k = 0; k < DEPTH; k++) begin
            push(DW'(18'h100 + k));
            check_levels(level);
        end
    endtask

    // R2: writes while full are dropped.
    task automatic t_overflow();
        for (int k = 0; k < 3; k++) push(DW'(18'h3A5A5 + k));
        check_levels(level);
        check("R2", "level held at depth", level, DEPTH);
    endtask

    // R8 and the thresholds from above: drain in order.
    task automatic t_drain();
        while (level > 0) begin
            #100;
            pop_check("R8");
            check_levels(level);
        end
    endtask

    // R3: reads while empty are ignored and the output holds.
    task automatic t_underflow();
        pop_check("R3");
        pop_check("R3");
        check_levels(0);
    endtask

    // R4 R5: zero offsets put the thresholds on the boundaries.
    task automatic t_zero_offsets();
        do_reset();
        ae_off = '0;
        af_off = '0;
        push(DW'(18'h00011));
        check_levels(level);
        for (int k = 1; k < DEPTH - 1; k++) push(DW'(18'h00011 + k));
        check_levels(level);
        push(DW'(18'h00020));
        check_levels(level);
        ae_off = PW'(3);
        af_off = PW'(4);
    endtask

    // R9 R10: rewind replays the stored words; a rewind with a read enable active is ignored.
    task automatic t_retransmit();
        do_reset();
        for (int k = 0; k < 5; k++) push(DW'(18'h2F000 + k));
        #100;
        pop_check("R9");
        pop_check("R9");
        #100;
        @(negedge rclk);
        rt = 1'b1;
        @(negedge rclk);
        rt = 1'b0;
        q = hist;
        level = hist.size();
        check_levels(level);
        for (int k = 0; k < 5; k++) pop_check("R9");
        check_levels(0);
        @(negedge rclk);
        rt    = 1'b1;
        ren_n = 1'b0;
        @(negedge rclk);
        rt    = 1'b0;
        ren_n = 1'b1;
        #100;
        check("R10", "empty_n after blocked rewind", int'(empty_n), 0);
        check("R10", "dout after blocked rewind", int'(dout), int'(last_rd));
    endtask

    // R8: streamed traffic that obeys the flags, with the pointers wrapping.
    task automatic t_stream();
        localparam int N = 60;
        do_reset();
        fork
            begin
                int sent = 0;
                while (sent < N) begin
                    @(negedge wclk);
                    if (full_n) begin
                        wen_n = 1'b0;
                        din   = DW'(sent * 37 + 5);
                        q.push_back(DW'(sent * 37 + 5));
                        sent++;
                    end else begin
                        wen_n = 1'b1;
                    end
                end
                @(negedge wclk);
                wen_n = 1'b1;
            end
            begin
                int  got = 0;
                logic issued = 1'b0;
                while (got < N) begin
                    @(negedge rclk);
                    if (issued) begin
                        check("R8", $sformatf("stream word %0d", got), int'(dout), int'(q.pop_front()));
                        got++;
                    end
                    issued = empty_n && (got < N);
                    ren_n  = !issued;
                end
                ren_n = 1'b1;
            end
        join
        level = 0;
        check_levels(0);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_sweep();
        t_overflow();
        t_drain();
        t_underflow();
        t_zero_offsets();
        t_retransmit();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule